// File: doc/BRIEF.md
# RV64 Shift-by-Immediate Unit

This block recognises the six RV64I shift-by-immediate instructions and executes them. Each cycle it takes a 32-bit instruction word and a 64-bit source operand. The six instructions are left logical, right logical and right arithmetic, each in a full 64-bit form and a 32-bit word form. For each one the block takes the shift amount from the instruction as an unsigned field. It does not use the sign-extended 12-bit immediate path that other I-type instructions take.

The block drives a result, the destination register index, a valid flag and an illegal-encoding flag. All four outputs are registered, so they appear one clock after the inputs are sampled. Reset is synchronous and active high. An instruction that is not a shift-immediate leaves every output at zero. A shift-immediate whose upper bits are malformed raises only the illegal flag.

Top module: `shimm_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs become zero on that edge, whatever the inputs are.
- R2: Full-width left shift (opcode 0010011, funct3 001) shifts `src_i` left by the unsigned amount in bits 25:20 (0 to 63), filling with zeros. Bit 31 never extends the amount.
- R3: Full-width right shift with bit 30 clear (funct3 101) is logical: it fills the vacated upper bits with zeros.
- R4: Full-width right shift with bit 30 set (funct3 101) is arithmetic: it fills the vacated bits with bit 63 of `src_i`.
- R5: Word left shift (opcode 0011011, funct3 001) shifts the low 32 bits of `src_i` by bits 24:20. The 32-bit result is sign-extended from its bit 31 into bits 63:32.
- R6: Word logical right shift (funct3 101, bit 30 clear) zero-fills the low 32 bits of the source, then sign-extends the 32-bit result.
- R7: Word arithmetic right shift (funct3 101, bit 30 set) fills with bit 31 of the source, then sign-extends the 32-bit result.
- R8: funct3 001 selects a left shift for any legal upper-bit pattern. Bit 30 plays no part in a left shift, so a full form with bits 31:26 = 010000 is still a legal left shift.
- R9: A full form with funct3 001 or 101 whose bits 31:26 are neither 000000 nor 010000 sets `illegal_o` and clears `valid_o`.
- R10: A word form with funct3 001 or 101 whose bits 31:25 are neither 0000000 nor 0100000 sets `illegal_o` and clears `valid_o`. This includes every encoding with bit 25 set.
- R11: Any other opcode, and any funct3 other than 001 or 101, drives `valid_o`, `illegal_o`, `rd_o` and `result_o` to zero.
- R12: When `valid_o` is high, `rd_o` equals bits 11:7 of the instruction. When `valid_o` is low, `result_o` and `rd_o` are zero, and `valid_o` and `illegal_o` are never high together.
- R13: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| src_i | input | 64 | Source operand value |
| result_o | output | 64 | Shift result, zero unless valid |
| rd_o | output | 5 | Destination register index, zero unless valid |
| valid_o | output | 1 | Legal shift-immediate executed |
| illegal_o | output | 1 | Malformed shift-immediate encoding |

## Verification
The assertions watch several properties on every cycle. Valid and illegal never overlap, and the outputs are zero whenever valid is low. A flagged output always traces back to a shift opcode and funct3. The destination index follows bits 11:7, every word result has its upper half equal to its bit 31, and a zero-amount full-width shift returns the operand unchanged. Only the bench's sweeps can show the exact shifted values for each of the six instructions, the boundary amounts 31, 32 and 63, and the exact split of upper-bit patterns into legal and illegal. The sweeps cover every upper-bit pattern and every amount for both opcodes and both funct3 values, with varied operands. The bench also shows the reset state, the one-cycle latency, and the fact that unrelated instructions are ignored.

// File: rtl/shimm_pkg.sv
package shimm_pkg;
  localparam int ILEN = 32;
  localparam int RIDX_W = 5;
  localparam int AMT_MAX_W = 6;

  localparam logic [6:0] OPC_FULL = 7'b0010011;
  localparam logic [6:0] OPC_WORD = 7'b0011011;
  localparam logic [2:0] F3_LEFT  = 3'b001;
  localparam logic [2:0] F3_RIGHT = 3'b101;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_LEFT   = 2'd1,
    SH_RLOG   = 2'd2,
    SH_RARITH = 2'd3
  } sh_kind_e;

  typedef struct packed {
    logic                 legal;
    logic                 bad;
    logic                 word;
    sh_kind_e             kind;
    logic [AMT_MAX_W-1:0] amt;
    logic [RIDX_W-1:0]    rd;
  } sh_dec_t;
endpackage

// File: rtl/shimm_decode.sv
module shimm_decode
  import shimm_pkg::*;
(
  input  logic [ILEN-1:0] insn,
  output sh_dec_t         dec
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [5:0] hi6;
  logic [6:0] hi7;
  logic       is_full;
  logic       is_word;
  logic       is_shift_f3;
  logic       full_bad;
  logic       word_bad;

  assign opc         = insn[6:0];
  assign f3          = insn[14:12];
  assign hi6         = insn[31:26];
  assign hi7         = insn[31:25];
  assign is_full     = (opc == OPC_FULL);
  assign is_word     = (opc == OPC_WORD);
  assign is_shift_f3 = (f3 == F3_LEFT) || (f3 == F3_RIGHT);
  assign full_bad    = !((hi6 == 6'b000000) || (hi6 == 6'b010000));
  assign word_bad    = insn[25] || !((hi7 == 7'b0000000) || (hi7 == 7'b0100000));

  always_comb begin
    dec = '0;
    if ((is_full || is_word) && is_shift_f3) begin
      dec.bad   = is_word ? word_bad : full_bad;
      dec.legal = !dec.bad;
      dec.word  = is_word;
      dec.amt   = is_word ? {1'b0, insn[24:20]} : insn[25:20];
      dec.rd    = insn[11:7];
      if (f3 == F3_LEFT) dec.kind = SH_LEFT;
      else if (insn[30]) dec.kind = SH_RARITH;
      else               dec.kind = SH_RLOG;
    end
  end
endmodule

// File: rtl/shimm_shifter.sv
module shimm_shifter
  import shimm_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  localparam int SHW  = $clog2(XLEN),
  localparam int WSHW = $clog2(WLEN)
) (
  input  logic [XLEN-1:0] src,
  input  sh_kind_e        kind,
  input  logic            word,
  input  logic [SHW-1:0]  amt,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] full_res;
  logic [WLEN-1:0] w_src;
  logic [WLEN-1:0] w_res;
  logic [WSHW-1:0] w_amt;
  logic [XLEN-1:0] w_ext;

  assign w_src = src[WLEN-1:0];
  assign w_amt = amt[WSHW-1:0];

  always_comb begin
    case (kind)
      SH_LEFT:   full_res = src << amt;
      SH_RLOG:   full_res = src >> amt;
      SH_RARITH: full_res = $unsigned($signed(src) >>> amt);
      default:   full_res = '0;
    endcase
  end

  always_comb begin
    case (kind)
      SH_LEFT:   w_res = w_src << w_amt;
      SH_RLOG:   w_res = w_src >> w_amt;
      SH_RARITH: w_res = $unsigned($signed(w_src) >>> w_amt);
      default:   w_res = '0;
    endcase
  end

  generate
    if (XLEN > WLEN) begin : g_ext
      assign w_ext = {{(XLEN-WLEN){w_res[WLEN-1]}}, w_res};
    end else begin : g_noext
      assign w_ext = w_res[XLEN-1:0];
    end
  endgenerate

  assign res = word ? w_ext : full_res;
endmodule

// File: rtl/shimm_outreg.sv
module shimm_outreg
  import shimm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              legal,
  input  logic              bad,
  input  logic [RIDX_W-1:0] rd,
  input  logic [XLEN-1:0]   res,
  output logic [XLEN-1:0]   result_q,
  output logic [RIDX_W-1:0] rd_q,
  output logic              valid_q,
  output logic              illegal_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result_q  <= '0;
      rd_q      <= '0;
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      result_q  <= legal ? res : '0;
      rd_q      <= legal ? rd : '0;
      valid_q   <= legal;
      illegal_q <= bad;
    end
  end
endmodule

// File: rtl/shimm_unit.sv
module shimm_unit
  import shimm_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ILEN-1:0]   insn_i,
  input  logic [XLEN-1:0]   src_i,
  output logic [XLEN-1:0]   result_o,
  output logic [RIDX_W-1:0] rd_o,
  output logic              valid_o,
  output logic              illegal_o
);
  sh_dec_t         dec;
  logic [XLEN-1:0] sh_res;

  shimm_decode u_dec (
    .insn (insn_i),
    .dec  (dec)
  );

  shimm_shifter #(.XLEN(XLEN), .WLEN(WLEN)) u_shift (
    .src  (src_i),
    .kind (dec.kind),
    .word (dec.word),
    .amt  (dec.amt[SHW-1:0]),
    .res  (sh_res)
  );

  shimm_outreg #(.XLEN(XLEN)) u_out (
    .clk       (clk),
    .rst       (rst),
    .legal     (dec.legal),
    .bad       (dec.bad),
    .rd        (dec.rd),
    .res       (sh_res),
    .result_q  (result_o),
    .rd_q      (rd_o),
    .valid_q   (valid_o),
    .illegal_q (illegal_o)
  );
endmodule

// File: rtl/shimm_unit_chk.sv
module shimm_unit_chk
  import shimm_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ILEN-1:0]   insn_i,
  input logic [XLEN-1:0]   src_i,
  input logic [XLEN-1:0]   result_o,
  input logic [RIDX_W-1:0] rd_o,
  input logic              valid_o,
  input logic              illegal_o
);
  // R12
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && illegal_o));

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (result_o == '0) && (rd_o == '0));

  // R11
  flag_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o || illegal_o) |->
      (($past(insn_i[6:0]) == OPC_FULL) || ($past(insn_i[6:0]) == OPC_WORD)));

  // R11
  flag_funct3_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o || illegal_o) |-> ($past(insn_i[13:12]) == 2'b01) && !$past(insn_i[14] ^ insn_i[14]));

  // R12
  rd_field_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (rd_o == $past(insn_i[11:7])));

  // R5
  word_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ($past(insn_i[6:0]) == OPC_WORD)) |->
      (result_o[XLEN-1:WLEN] == {(XLEN-WLEN){result_o[WLEN-1]}}));

  // R2
  zero_amount_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ($past(insn_i[6:0]) == OPC_FULL) && ($past(insn_i[25:20]) == 6'd0)) |->
      (result_o == $past(src_i)));
endmodule

bind shimm_unit shimm_unit_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .insn_i    (insn_i),
  .src_i     (src_i),
  .result_o  (result_o),
  .rd_o      (rd_o),
  .valid_o   (valid_o),
  .illegal_o (illegal_o)
);

// File: tb/shimm_unit_test.sv
module shimm_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn_i = '0;
  logic [63:0] src_i = '0;
  logic [63:0] result_o;
  logic [4:0]  rd_o;
  logic        valid_o;
  logic        illegal_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;
  logic [70:0] prev_exp = '0;

  always #2 clk = ~clk;

  shimm_unit uut (
    .clk(clk), .rst(rst), .insn_i(insn_i), .src_i(src_i),
    .result_o(result_o), .rd_o(rd_o), .valid_o(valid_o), .illegal_o(illegal_o)
  );

  // Reference: {valid, illegal, rd[4:0], result[63:0]}, built bit by bit.
  function automatic logic [70:0] ref_model(logic [31:0] i, logic [63:0] s);
    logic [6:0]  opc = i[6:0];
    logic [2:0]  f3 = i[14:12];
    bit full = (opc == 7'b0010011);
    bit word = (opc == 7'b0011011);
    bit bad;
    int amt;
    logic [63:0] r = '0;
    logic [31:0] w = '0;
    if (!((full || word) && (f3 == 3'd1 || f3 == 3'd5))) return '0;
    if (full) bad = !(i[31:26] == 6'd0 || i[31:26] == 6'b010000);
    else      bad = !(i[31:25] == 7'd0 || i[31:25] == 7'b0100000);
    if (bad) return {1'b0, 1'b1, 5'd0, 64'd0};
    if (full) begin
      amt = int'(i[25:20]);
      for (int k = 0; k < 64; k++) begin
        if (f3 == 3'd1)           r[k] = (k >= amt) ? s[k-amt] : 1'b0;
        else if (k + amt < 64)    r[k] = s[k+amt];
        else                      r[k] = i[30] ? s[63] : 1'b0;
      end
    end else begin
      amt = int'(i[24:20]);
      for (int k = 0; k < 32; k++) begin
        if (f3 == 3'd1)           w[k] = (k >= amt) ? s[k-amt] : 1'b0;
        else if (k + amt < 32)    w[k] = s[k+amt];
        else                      w[k] = i[30] ? s[31] : 1'b0;
      end
      for (int k = 0; k < 64; k++) r[k] = (k < 32) ? w[k] : w[31];
    end
    return {1'b1, 1'b0, i[11:7], r};
  endfunction

  function automatic string tag_of(logic [31:0] i);
    logic [70:0] e = ref_model(i, '0);
    bit full = (i[6:0] == 7'b0010011);
    if (!e[70] && !e[69]) return "R11/R12";
    if (e[69]) return full ? "R9" : "R10";
    if (i[14:12] == 3'd1) begin
      if (i[30]) return "R8";
      return full ? "R2" : "R5";
    end
    if (full) return i[30] ? "R4" : "R3";
    return i[30] ? "R7" : "R6";
  endfunction

  task automatic compare(string tag, logic [70:0] exp);
    logic [70:0] act = {valid_o, illegal_o, rd_o, result_o};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual v=%b i=%b rd=%0d res=%h expected v=%b i=%b rd=%0d res=%h",
               tag, act[70], act[69], act[68:64], act[63:0],
               exp[70], exp[69], exp[68:64], exp[63:0]);
    end
  endtask

  task automatic next_src(int idx, output logic [63:0] s);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    case (idx % 4)
      0: s = seed;
      1: s = {1'b1, seed[62:32], 1'b1, seed[30:0]};
      2: s = '1;
      default: s = {1'b0, seed[62:32], 1'b0, seed[30:0]};
    endcase
  endtask

  task automatic apply(logic [31:0] i, logic [63:0] s, bit lat_chk);
    logic [70:0] exp = ref_model(i, s);
    @(negedge clk);
    insn_i = i;
    src_i  = s;
    #1;
    if (lat_chk) compare("R13", prev_exp); // R13: no change before the edge
    @(negedge clk);
    compare(tag_of(i), exp);
    prev_exp = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] s;
    // R1: reset clears outputs with a legal shift on the inputs
    insn_i = {6'd0, 6'd3, 5'd1, 3'd1, 5'd9, 7'b0010011};
    src_i  = '1;
    repeat (3) @(negedge clk);
    compare("R1", '0);
    rst = 1'b0;
    @(negedge clk);
    compare("R13", ref_model(insn_i, src_i));
    prev_exp = ref_model(insn_i, src_i);
    // Mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); compare("R1", '0);
    rst = 1'b0;
    prev_exp = ref_model(insn_i, src_i);
    @(negedge clk);

    // Exhaustive sweep over upper bits and amount for both opcodes and shift funct3 values
    for (int oc = 0; oc < 2; oc++)
      for (int fs = 0; fs < 2; fs++)
        for (int up = 0; up < 128; up++)
          for (int lo = 0; lo < 32; lo++) begin
            logic [31:0] i;
            next_src(up + lo, s);
            i = {up[6:0], lo[4:0], seed[4:0], (fs == 0) ? 3'd1 : 3'd5,
                 5'((up * 7 + lo) % 32), (oc == 0) ? 7'b0010011 : 7'b0011011};
            apply(i, s, (lo % 8) == 0);
          end

    // R11: other funct3 values and other opcodes are ignored
    for (int f = 0; f < 8; f++)
      for (int oc = 0; oc < 4; oc++) begin
        logic [6:0] opc;
        case (oc)
          0: opc = 7'b0010011;
          1: opc = 7'b0011011;
          2: opc = 7'b0110011;
          default: opc = 7'b0111011;
        endcase
        for (int up = 0; up < 4; up++) begin
          next_src(up, s);
          apply({(up == 1) ? 7'b0100000 : 7'(up * 5), 5'd4, 5'd2, f[2:0], 5'd17, opc}, s, 1'b1);
        end
      end

    // R8: full left shift with bit 30 set stays a legal left shift
    apply({6'b010000, 6'd63, 5'd0, 3'd1, 5'd31, 7'b0010011}, 64'h1, 1'b1);
    apply({6'b010000, 6'd0, 5'd0, 3'd1, 5'd1, 7'b0010011}, 64'hDEAD_BEEF_0123_4567, 1'b1);
    // R4 and R7 boundaries
    apply({6'b010000, 6'd63, 5'd0, 3'd5, 5'd3, 7'b0010011}, 64'h8000_0000_0000_0000, 1'b1);
    apply({7'b0100000, 5'd31, 5'd0, 3'd5, 5'd3, 7'b0011011}, 64'h0000_0000_8000_0000, 1'b1);
    // R6: word logical right by zero of a negative word
    apply({7'b0000000, 5'd0, 5'd0, 3'd5, 5'd6, 7'b0011011}, 64'h1234_5678_8000_0001, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule